// File: doc/BRIEF.md
# Paced Transmit-Empty Status Generator

This block produces the transmit-holding-register-empty status of a UART-emulation bridge. The bridge sits between a host bus and a local processor. When the host writes a byte into the holding register, the local processor gets an interrupt. The local processor then reads the byte. From that read on, the block keeps two separate empty indications.

The local processor's own copy of the empty bit is set at once. This copy is the one it sees in its line status. The host's copy can be held back by a programmable pacing timer. The timer counts baud-generator ticks, so the host cannot refill the register faster than a real serial shifter would drain it. When the count ends, the host's empty bit is set and a one-cycle permit pulse is sent to the double-buffer path. That path uses the pulse to move the byte into the transmit shift buffer.

Top module: `thre_pacer`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, host_empty=1, local_empty=1, local_irq=0 and xfer_permit=0.
- R2: A cycle with host_wr=1 makes host_empty=0, local_empty=0 and local_irq=1 on the next clock, and cancels any running count.
- R3: A cycle with local_rd=1 and host_wr=0 makes local_empty=1 and local_irq=0 on the next clock.
- R4: A paced read is local_rd=1 with pace_en=1 and host_wr=0. It loads the constant N. host_empty rises on the clock that follows the N-th tick cycle after that read, and not before. A constant of 0 behaves as 1.
- R5: An unpaced read is local_rd=1 with pace_en=0 and host_wr=0. It sets host_empty on the next clock and produces no permit pulse.
- R6: A timer expiry raises xfer_permit for exactly one cycle. This is the same cycle in which host_empty becomes 1. No other event raises xfer_permit.
- R7: A host write while the count runs aborts it. host_empty stays 0 and no permit pulse follows, however many ticks arrive afterwards.
- R8: When host_wr and local_rd are both 1 in the same cycle, the write takes effect and the read is ignored: local_irq=1, local_empty=0 and host_empty=0.
- R9: A paced read while a count runs restarts the count from the constant.
- R10: Ticks while no count runs have no effect. pace_en is sampled only at the read, so changing it during a count does not alter that count.
- R11: The full 24-bit constant is honoured. With the constant 0x010002 and a tick in every cycle, host_empty is still 0 after 65537 tick cycles and is 1 after 65538.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe to the holding register |
| local_rd | input | 1 | Local processor read strobe of the holding register |
| pace_en | input | 1 | Enables pacing of the host empty status |
| pace_const | input | 24 | Pacing time constant in baud ticks |
| tick | input | 1 | Baud-generator tick, one cycle wide |
| host_empty | output | 1 | Empty bit seen by the host (paced) |
| local_empty | output | 1 | Mirrored empty bit seen by the local processor |
| local_irq | output | 1 | Interrupt to the local processor |
| xfer_permit | output | 1 | One-cycle pulse on timer expiry for the double-buffer move |

## Verification
The assertions check the strobe reactions on every cycle:
- the write clearing both empty bits and raising the interrupt;
- the read setting the mirrored bit;
- the unpaced read setting the host bit;
- the permit being a lone pulse that coincides with a rise of host_empty, and never coming from an idle timer.

The length of the pacing delay can only be shown by the bench scenarios. The same holds for abort after a host write, restart on a repeated read, the enable being sampled at the read, and the full-width constant. These scenarios are run as directed sequences and as a long random mix compared against a cycle model.

// File: rtl/thre_pkg.sv
// Shared types for the paced transmit-empty status generator.
// Assumes nothing beyond a single clock domain.
package thre_pkg;
    parameter int unsigned PACE_W_DEF = 24;

    // Registered status bits held by the flag controller.
    typedef struct packed {
        logic host_empty;
        logic local_empty;
        logic irq;
    } thre_flags_t;

    localparam thre_flags_t FLAGS_RESET = '{host_empty: 1'b1, local_empty: 1'b1, irq: 1'b0};
endpackage

// File: rtl/pace_timer.sv
// Down-counting pacing timer clocked by baud ticks.
// Assumes start and abort are single-cycle strobes. start has priority over abort.
// done is combinational: high in the tick cycle that ends the count.
module pace_timer #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Expiry: running, ticking, at the last step, and not overridden by a strobe.
    assign done = busy && tick && (cnt <= ONE) && !abort;

    // Load, abort, decrement and expiry of the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load_val;
        end else if (abort || done) begin
            busy <= 1'b0;
        end else if (busy && tick) begin
            cnt <= cnt - ONE;
        end
    end

    // R10
    idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
    // R4
    load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/empty_flags.sv
// Holds the host and local empty bits, the local interrupt and the permit pulse.
// Assumes done comes from the pacing timer and is low whenever host_wr or local_rd is high.
module empty_flags
    import thre_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    input  logic local_rd,
    input  logic pace_en,
    input  logic done,
    output logic host_empty,
    output logic local_empty,
    output logic local_irq,
    output logic xfer_permit
);
    thre_flags_t flags;

    // Update the status bits. A write wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= FLAGS_RESET;
        end else if (host_wr) begin
            flags <= '{host_empty: 1'b0, local_empty: 1'b0, irq: 1'b1};
        end else if (local_rd) begin
            flags.local_empty <= 1'b1;
            flags.irq         <= 1'b0;
            if (!pace_en) flags.host_empty <= 1'b1;
        end else if (done) begin
            flags.host_empty <= 1'b1;
        end
    end

    // Register the expiry as the transfer-permit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_permit <= 1'b0;
        else        xfer_permit <= done;
    end

    assign host_empty  = flags.host_empty;
    assign local_empty = flags.local_empty;
    assign local_irq   = flags.irq;

    // R2
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (!host_empty && !local_empty && local_irq));
    // R3
    rd_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_rd && !host_wr) |=> (local_empty && !local_irq));
    // R5
    unpaced_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_rd && !host_wr && !pace_en) |=> (host_empty && !xfer_permit));
    // R6
    permit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_permit |=> !xfer_permit);
endmodule

// File: rtl/thre_pacer.sv
// Top of the paced transmit-empty status generator.
// A host write raises the local interrupt. The local read sets the mirrored bit at once.
// It sets the host bit either at once or after a tick-paced delay.
// Assumes all strobes are synchronous to clk and one cycle wide.
module thre_pacer #(
    parameter int unsigned PACE_W = thre_pkg::PACE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              local_rd,
    input  logic              pace_en,
    input  logic [PACE_W-1:0] pace_const,
    input  logic              tick,
    output logic              host_empty,
    output logic              local_empty,
    output logic              local_irq,
    output logic              xfer_permit
);
    logic tmr_start;
    logic tmr_abort;
    logic tmr_busy;
    logic tmr_done;

    // Any strobe ends a running count. Only a paced read that no write overrides starts one.
    assign tmr_start = local_rd && !host_wr && pace_en;
    assign tmr_abort = host_wr || local_rd;

    pace_timer #(.CNT_W(PACE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .abort    (tmr_abort),
        .tick     (tick),
        .load_val (pace_const),
        .busy     (tmr_busy),
        .done     (tmr_done)
    );

    empty_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .local_rd    (local_rd),
        .pace_en     (pace_en),
        .done        (tmr_done),
        .host_empty  (host_empty),
        .local_empty (local_empty),
        .local_irq   (local_irq),
        .xfer_permit (xfer_permit)
    );

    // R6
    permit_with_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_permit |-> host_empty);
    // R10
    idle_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_busy |=> !xfer_permit);
    // R4
    empty_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_empty) |-> (xfer_permit || $past(local_rd && !host_wr && !pace_en)));
    // R7
    write_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> !xfer_permit);
endmodule

// File: tb/thre_pacer_bench.sv
module thre_pacer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, local_rd = 1'b0, pace_en = 1'b0, tick = 1'b0;
    logic [23:0] pace_const = '0;
    logic        host_empty, local_empty, local_irq, xfer_permit;

    int checks = 0;
    int fails  = 0;

    // cycle model state
    logic        m_he = 1'b1, m_le = 1'b1, m_irq = 1'b0, m_perm = 1'b0, m_busy = 1'b0;
    logic [23:0] m_cnt = '0;

    always #5 clk = ~clk;

    thre_pacer u_thre_pacer (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .local_rd(local_rd),
        .pace_en(pace_en), .pace_const(pace_const), .tick(tick),
        .host_empty(host_empty), .local_empty(local_empty),
        .local_irq(local_irq), .xfer_permit(xfer_permit)
    );

    function automatic logic model_done(logic busy, logic [23:0] cnt, logic t, logic w, logic r);
        return busy && t && (cnt <= 24'd1) && !w && !r;
    endfunction

    task automatic model_step();
        logic d;
        d = model_done(m_busy, m_cnt, tick, host_wr, local_rd);
        m_perm = d;
        if (host_wr) begin
            m_he = 0; m_le = 0; m_irq = 1; m_busy = 0;
        end else if (local_rd) begin
            m_le = 1; m_irq = 0;
            if (pace_en) begin m_busy = 1; m_cnt = pace_const; end
            else begin m_he = 1; m_busy = 0; end
        end else if (d) begin
            m_he = 1; m_busy = 0;
        end else if (m_busy && tick) begin
            m_cnt = m_cnt - 24'd1;
        end
    endtask

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of inputs; outputs are sampled 1 ns after the edge.
    task automatic cyc(logic w, logic r, logic en, logic t);
        host_wr = w; local_rd = r; pace_en = en; tick = t;
        @(posedge clk);
        if (rst_n) model_step();
        #1;
        host_wr = 0; local_rd = 0; tick = 0;
    endtask

    task automatic check_all(string tag);
        check({tag, " host_empty"}, host_empty, m_he);
        check({tag, " local_empty"}, local_empty, m_le);
        check({tag, " local_irq"}, local_irq, m_irq);
        check({tag, " xfer_permit"}, xfer_permit, m_perm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4177);
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        check("R1 host_empty in reset", host_empty, 1'b1);
        check("R1 irq in reset", local_irq, 1'b0);
        rst_n = 1;
        cyc(0, 0, 0, 0);
        check("R1 local_empty", local_empty, 1'b1);
        check("R1 xfer_permit", xfer_permit, 1'b0);

        // R2 host write
        cyc(1, 0, 0, 0);
        check("R2 host_empty", host_empty, 1'b0);
        check("R2 local_empty", local_empty, 1'b0);
        check("R2 local_irq", local_irq, 1'b1);

        // R3 paced read, R4 delay, R6 pulse
        pace_const = 24'd3;
        cyc(0, 1, 1, 0);
        check("R3 local_empty", local_empty, 1'b1);
        check("R3 local_irq", local_irq, 1'b0);
        check("R4 host_empty after read", host_empty, 1'b0);
        cyc(0, 0, 1, 1); cyc(0, 0, 1, 0); cyc(0, 0, 1, 1);
        check("R4 host_empty after 2 ticks", host_empty, 1'b0);
        cyc(0, 0, 1, 1);
        check("R4 host_empty after 3 ticks", host_empty, 1'b1);
        check("R6 permit on expiry", xfer_permit, 1'b1);
        cyc(0, 0, 1, 0);
        check("R6 permit one cycle", xfer_permit, 1'b0);

        // R5 unpaced read
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0);
        check("R5 host_empty", host_empty, 1'b1);
        check("R5 xfer_permit", xfer_permit, 1'b0);
        cyc(0, 0, 0, 0);
        check("R5 no later permit", xfer_permit, 1'b0);

        // R7 abort
        cyc(1, 0, 0, 0);
        pace_const = 24'd2;
        cyc(0, 1, 1, 0);
        cyc(0, 0, 1, 1);
        cyc(1, 0, 1, 1);
        check("R7 host_empty after abort", host_empty, 1'b0);
        begin
            logic seen = 0;
            for (int i = 0; i < 6; i++) begin
                cyc(0, 0, 1, 1);
                if (xfer_permit || host_empty) seen = 1;
            end
            check("R7 no expiry after abort", seen, 1'b0);
        end

        // R8 simultaneous write and read
        cyc(0, 1, 0, 0);
        cyc(1, 1, 0, 0);
        check("R8 local_irq", local_irq, 1'b1);
        check("R8 local_empty", local_empty, 1'b0);
        check("R8 host_empty", host_empty, 1'b0);

        // R9 restart
        pace_const = 24'd3;
        cyc(0, 1, 1, 0);
        cyc(0, 0, 1, 1); cyc(0, 0, 1, 1);
        cyc(0, 1, 1, 0);
        cyc(0, 0, 1, 1); cyc(0, 0, 1, 1);
        check("R9 not expired after restart", host_empty, 1'b0);
        cyc(0, 0, 1, 1);
        check("R9 expiry after full restart", host_empty, 1'b1);

        // R10 idle ticks and enable drop
        begin
            logic seen = 0;
            for (int i = 0; i < 5; i++) begin
                cyc(0, 0, 0, 1);
                if (xfer_permit || !host_empty) seen = 1;
            end
            check("R10 idle ticks ignored", seen, 1'b0);
        end
        cyc(1, 0, 0, 0);
        pace_const = 24'd2;
        cyc(0, 1, 1, 0);
        cyc(0, 0, 0, 1);
        check("R10 still counting with enable low", host_empty, 1'b0);
        cyc(0, 0, 0, 1);
        check("R10 expiry with enable low", host_empty, 1'b1);

        // R4 constant zero acts as one
        cyc(1, 0, 0, 0);
        pace_const = 24'd0;
        cyc(0, 1, 1, 0);
        cyc(0, 0, 1, 0);
        check("R4 zero const waits for tick", host_empty, 1'b0);
        cyc(0, 0, 1, 1);
        check("R4 zero const first tick", host_empty, 1'b1);

        // R11 full-width constant
        cyc(1, 0, 0, 0);
        pace_const = 24'h010002;
        cyc(0, 1, 1, 0);
        begin
            logic early = 0;
            for (int i = 0; i < 65537; i++) begin
                cyc(0, 0, 1, 1);
                if (host_empty) early = 1;
            end
            check("R11 no early expiry", early, 1'b0);
        end
        cyc(0, 0, 1, 1);
        check("R11 expiry at 65538 ticks", host_empty, 1'b1);
        check_all("R11 model sync");

        // random mix against the cycle model
        for (int i = 0; i < 3000; i++) begin
            logic w, r, e, t;
            if ($urandom % 50 == 0) pace_const = 24'($urandom % 6);
            w = ($urandom % 20 == 0);
            r = ($urandom % 6 == 0);
            e = ($urandom % 4 != 0);
            t = ($urandom % 3 == 0);
            cyc(w, r, e, t);
            check("R4 random host_empty", host_empty, m_he);
            check("R3 random local_empty", local_empty, m_le);
            check("R2 random local_irq", local_irq, m_irq);
            check("R6 random xfer_permit", xfer_permit, m_perm);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule